// File: doc/BRIEF.md
# Dual-Port Address Collision Busy Arbiter

This block sits beside a memory array that two independent ports share. Each cycle it compares the two ports' enables and addresses. When both ports are enabled on the same location, it grants the location to one port and drives an active-low busy flag toward the other. A write strobe from a port that is held off is dropped before it reaches the array. The read/write direction of either port plays no part in the decision. The block holds no array storage of its own.

A mode input picks one of two roles. As a master, the block arbitrates and drives both busy flags. As a slave, it does no arbitration of its own. Its busy outputs stay high and two busy inputs, fed from a master elsewhere, serve only as per-port write inhibits. Several parts can then follow one master and all reach the same decision. The block keeps the request of each port from the previous clock edge, so it can tell an established request from one that has just arrived. It also keeps the current owner of a contested location. A same-cycle decision is made from the current inputs and this registered history. The array commits gated writes at the next rising edge.

Top module: `dpram_collide_arb`

## Requirements
- R1: In master mode a busy output is low only while both enables are high and the two addresses are equal. Otherwise both busy outputs are high.
- R2: The read/write direction inputs have no effect on the busy outputs or on the owner decision.
- R3: The two busy outputs are never low at the same time.
- R4: A port is "new" in a cycle when it is enabled and either was disabled at the previous edge or had a different address then. When the ports first collide, the port that was already established wins if the other is new. The new port's busy goes low.
- R5: When both colliding requests are new in the same cycle, the left port wins and busy_r_n goes low.
- R6: While the collision persists and the owner's request is unchanged since the previous edge, the owner keeps the grant, even if the losing port re-arrives. When the collision ends, the grant is released and both busy outputs return high.
- R7: A port's write-inhibit is high in master mode exactly when its own busy output is low. A port's array write strobe (x_wr_go) is high only when that port's enable and write inputs are high and its write-inhibit is low.
- R8: In slave mode (master = 0) both busy outputs stay high. Each port's write-inhibit equals the inverse of its busy input (active low). Holding a busy input low blocks every write from that port, and holding it high passes writes.
- R9: While rst is high, both busy outputs are high and the history is cleared. In the first cycle after reset, a collision is therefore treated as a simultaneous arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| master | input | 1 | 1 = arbitrate and drive busy, 0 = follow busy inputs |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | AW (12) | Left port address |
| l_wr | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | AW (12) | Right port address |
| r_wr | input | 1 | Right port write request |
| busy_in_l_n | input | 1 | Slave-mode left write inhibit, active low |
| busy_in_r_n | input | 1 | Slave-mode right write inhibit, active low |
| busy_l_n | output | 1 | Left busy, active low |
| busy_r_n | output | 1 | Right busy, active low |
| wr_inhibit_l | output | 1 | Left writes blocked |
| wr_inhibit_r | output | 1 | Right writes blocked |
| l_wr_go | output | 1 | Left write strobe to the array |
| r_wr_go | output | 1 | Right write strobe to the array |

## Verification
Two events can fall in the same cycle: a fresh collision decision, and a write strobe that this decision must suppress. The losing port may be presenting a write in the very cycle it loses. Random stimulus draws addresses from a small pool so that collisions, re-arrivals and simultaneous arrivals occur often, with writes asserted at random on both sides. Directed steps add reset, a left-first case, a right-first case, a tie, a hold, a release and slave-mode cases. Each cycle, an age-based bench model predicts the owner, both busy flags, both inhibits and both write strobes, and all six are compared.

// File: rtl/dca_pkg.sv
package dca_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  // Owner for this cycle from collision, previous owner and arrival flags.
  function automatic owner_t pick_owner(input logic   hit,
                                        input owner_t prev,
                                        input logic   l_new,
                                        input logic   r_new);
    owner_t res;
    if (!hit)                                res = OWN_NONE;
    else if (prev == OWN_LEFT  && !l_new)    res = OWN_LEFT;
    else if (prev == OWN_RIGHT && !r_new)    res = OWN_RIGHT;
    else if (l_new && !r_new)                res = OWN_RIGHT;
    else                                     res = OWN_LEFT;
    return res;
  endfunction

endpackage

// File: rtl/dca_req_track.sv
module dca_req_track #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          is_new
);
  logic          en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  assign is_new = en && (!en_q || (addr != addr_q));
endmodule

// File: rtl/dca_arbiter.sv
module dca_arbiter #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          l_new,
  input  logic          r_new,
  output logic          hit,
  output logic          lose_l,
  output logic          lose_r
);
  import dca_pkg::*;

  owner_t owner_q;
  owner_t owner_d;

  assign hit = l_en && r_en && (l_addr == r_addr);

  always_comb begin
    if (rst) owner_d = OWN_NONE;
    else     owner_d = pick_owner(hit, owner_q, l_new, r_new);
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner_d;
  end

  assign lose_l = (owner_d == OWN_RIGHT);
  assign lose_r = (owner_d == OWN_LEFT);
endmodule

// File: rtl/dca_wr_gate.sv
module dca_wr_gate (
  input  logic master,
  input  logic lose,
  input  logic busy_in_n,
  input  logic en,
  input  logic wr,
  output logic busy_n,
  output logic inhibit,
  output logic wr_go
);
  assign busy_n  = !(master && lose);
  assign inhibit = master ? lose : !busy_in_n;
  assign wr_go   = en && wr && !inhibit;
endmodule

// File: rtl/dpram_collide_arb.sv
module dpram_collide_arb #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wr,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wr,
  input  logic          busy_in_l_n,
  input  logic          busy_in_r_n,
  output logic          busy_l_n,
  output logic          busy_r_n,
  output logic          wr_inhibit_l,
  output logic          wr_inhibit_r,
  output logic          l_wr_go,
  output logic          r_wr_go
);
  localparam int NP = 2;

  logic          l_new, r_new, hit, lose_l, lose_r;
  logic [NP-1:0] lose_v, bin_v, en_v, wr_v, busy_v, inh_v, go_v;

  dca_req_track #(.AW(AW)) trk_l (.clk(clk), .rst(rst), .en(l_en), .addr(l_addr), .is_new(l_new));
  dca_req_track #(.AW(AW)) trk_r (.clk(clk), .rst(rst), .en(r_en), .addr(r_addr), .is_new(r_new));

  dca_arbiter #(.AW(AW)) arb_i (
    .clk(clk), .rst(rst),
    .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
    .l_new(l_new), .r_new(r_new),
    .hit(hit), .lose_l(lose_l), .lose_r(lose_r)
  );

  assign lose_v = {lose_r, lose_l};
  assign bin_v  = {busy_in_r_n, busy_in_l_n};
  assign en_v   = {r_en, l_en};
  assign wr_v   = {r_wr, l_wr};

  for (genvar p = 0; p < NP; p++) begin : g_port
    dca_wr_gate gate_i (
      .master(master), .lose(lose_v[p]), .busy_in_n(bin_v[p]),
      .en(en_v[p]), .wr(wr_v[p]),
      .busy_n(busy_v[p]), .inhibit(inh_v[p]), .wr_go(go_v[p])
    );
  end

  assign busy_l_n     = busy_v[0];
  assign busy_r_n     = busy_v[1];
  assign wr_inhibit_l = inh_v[0];
  assign wr_inhibit_r = inh_v[1];
  assign l_wr_go      = go_v[0];
  assign r_wr_go      = go_v[1];
endmodule

// File: rtl/dca_checker.sv
module dca_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          master,
  input logic          l_en,
  input logic [AW-1:0] l_addr,
  input logic          l_wr,
  input logic          r_en,
  input logic [AW-1:0] r_addr,
  input logic          r_wr,
  input logic          busy_in_l_n,
  input logic          busy_in_r_n,
  input logic          busy_l_n,
  input logic          busy_r_n,
  input logic          wr_inhibit_l,
  input logic          wr_inhibit_r,
  input logic          l_wr_go,
  input logic          r_wr_go
);
  logic coll;
  assign coll = l_en && r_en && (l_addr == r_addr);

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!busy_l_n && !busy_r_n)); // R3

  AST_BUSY_NEEDS_COLLISION: assert property (@(posedge clk) disable iff (rst)
    (!busy_l_n || !busy_r_n) |-> (coll && master)); // R1

  AST_SLAVE_BUSY_HIGH: assert property (@(posedge clk) disable iff (rst)
    !master |-> (busy_l_n && busy_r_n)); // R8

  AST_SLAVE_INHIBIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !master |-> (wr_inhibit_l == !busy_in_l_n) && (wr_inhibit_r == !busy_in_r_n)); // R8

  AST_BLOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_inhibit_l |-> !l_wr_go) and (wr_inhibit_r |-> !r_wr_go)); // R7

  AST_CLEAR_WRITE_PASSES: assert property (@(posedge clk) disable iff (rst)
    (l_en && l_wr && !wr_inhibit_l) |-> l_wr_go); // R7

  AST_CLEAR_WRITE_PASSES_R: assert property (@(posedge clk) disable iff (rst)
    (r_en && r_wr && !wr_inhibit_r) |-> r_wr_go); // R7

  AST_TIE_GOES_LEFT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && master && coll && !$past(l_en) && !$past(r_en)) |-> !busy_r_n); // R5

  AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && master && $past(master) && !$past(busy_r_n) && coll &&
     $past(l_en) && $stable(l_addr)) |-> !busy_r_n); // R6
endmodule

bind dpram_collide_arb dca_checker #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .master(master),
  .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
  .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
  .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n),
  .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
  .wr_inhibit_l(wr_inhibit_l), .wr_inhibit_r(wr_inhibit_r),
  .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
);

// File: tb/dpram_collide_arb_tb.sv
module dpram_collide_arb_tb_top;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst, master, l_en, r_en, l_wr, r_wr, bin_l, bin_r;
  logic [AW-1:0] l_addr, r_addr;
  logic busy_l_n, busy_r_n, inh_l, inh_r, go_l, go_r;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model: request ages (-1 = disabled, 0 = new), owner 0/1/2
  int m_l_age, m_r_age, m_own;
  logic m_l_en_p, m_r_en_p;
  logic [AW-1:0] m_l_addr_p, m_r_addr_p;
  int e_own, e_l_age, e_r_age;

  always #10 clk = ~clk;

  dpram_collide_arb #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .master(master),
    .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
    .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
    .busy_in_l_n(bin_l), .busy_in_r_n(bin_r),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .wr_inhibit_l(inh_l), .wr_inhibit_r(inh_r),
    .l_wr_go(go_l), .r_wr_go(go_r)
  );

  function automatic int age_of(logic en, logic [AW-1:0] a, logic en_p,
                                logic [AW-1:0] a_p, int old);
    if (!en) return -1;
    if (en_p && a == a_p) return old + 1;
    return 0;
  endfunction

  function automatic int owner_of(bit coll, int prev, int la, int ra);
    if (!coll) return 0;
    if (prev == 1 && la > 0) return 1;
    if (prev == 2 && ra > 0) return 2;
    return (ra > la) ? 2 : 1;
  endfunction

  task automatic cmp(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit coll;
    logic xb_l, xb_r, xi_l, xi_r;
    #5;
    coll = l_en && r_en && (l_addr == r_addr);
    if (rst) begin
      e_own = 0; e_l_age = -1; e_r_age = -1;
    end else begin
      e_l_age = age_of(l_en, l_addr, m_l_en_p, m_l_addr_p, m_l_age);
      e_r_age = age_of(r_en, r_addr, m_r_en_p, m_r_addr_p, m_r_age);
      e_own   = owner_of(coll, m_own, e_l_age, e_r_age);
    end
    xb_l = !(master && e_own == 2);
    xb_r = !(master && e_own == 1);
    xi_l = master ? (e_own == 2) : !bin_l;
    xi_r = master ? (e_own == 1) : !bin_r;
    cmp(tag, "busy_l_n", busy_l_n, xb_l);
    cmp(tag, "busy_r_n", busy_r_n, xb_r);
    cmp(tag, "wr_inhibit_l", inh_l, xi_l);
    cmp(tag, "wr_inhibit_r", inh_r, xi_r);
    cmp(tag, "l_wr_go", go_l, l_en && l_wr && !xi_l);
    cmp(tag, "r_wr_go", go_r, r_en && r_wr && !xi_r);
    @(posedge clk);
    if (rst) begin
      m_l_en_p = 1'b0; m_r_en_p = 1'b0; m_l_age = -1; m_r_age = -1; m_own = 0;
      m_l_addr_p = '0; m_r_addr_p = '0;
    end else begin
      m_l_en_p = l_en; m_r_en_p = r_en; m_l_addr_p = l_addr; m_r_addr_p = r_addr;
      m_l_age = e_l_age; m_r_age = e_r_age; m_own = e_own;
    end
    @(negedge clk);
  endtask

  task automatic drv(logic le, logic [AW-1:0] la, logic lw,
                     logic re, logic [AW-1:0] ra, logic rw);
    l_en = le; l_addr = la; l_wr = lw; r_en = re; r_addr = ra; r_wr = rw;
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst = 1; master = 1; bin_l = 1; bin_r = 1;
    drv(1, 12'h0AB, 1, 1, 12'h0AB, 1);
    @(negedge clk);
    // R9: busy released during reset even with colliding inputs
    step("R9"); step("R9");
    rst = 0;
    // R9: first cycle after reset treated as a tie -> left wins
    step("R9");
    step("R6");
    // R1: addresses differ -> no busy
    drv(1, 12'h010, 1, 1, 12'h011, 1); step("R1");
    // R4: left established, right arrives later -> right busy
    drv(1, 12'h020, 1, 0, 12'h000, 0); step("R4");
    drv(1, 12'h020, 1, 1, 12'h020, 1); step("R4");
    // R2: toggling direction keeps the decision
    drv(1, 12'h020, 0, 1, 12'h020, 0); step("R2");
    // R6: loser re-arrives, owner keeps grant
    drv(1, 12'h020, 1, 0, 12'h020, 1); step("R6");
    drv(1, 12'h020, 1, 1, 12'h020, 1); step("R6");
    // R6: release when the owner drops
    drv(0, 12'h020, 0, 1, 12'h020, 1); step("R6");
    // R4: right established, left arrives later -> left busy, write blocked (R7)
    drv(0, 12'h000, 0, 1, 12'h333, 0); step("R4");
    drv(1, 12'h333, 1, 1, 12'h333, 0); step("R7");
    // R5: both arrive together on a new address
    drv(1, 12'hFFF, 1, 1, 12'hFFF, 1); step("R5");
    // R8: slave mode, busy inputs drive inhibits
    master = 0; bin_l = 0; bin_r = 1;
    for (int i = 0; i < 4; i++) begin
      drv(1, 12'(i), 1, 1, 12'(i), 1); step("R8");
    end
    bin_l = 1; bin_r = 0; step("R8");
    bin_r = 1; step("R8");
    master = 1;
    // random mix
    for (int i = 0; i < 3000; i++) begin
      drv($urandom_range(0, 3) != 0, 12'($urandom_range(0, 3)), 1'($urandom),
          $urandom_range(0, 3) != 0, 12'($urandom_range(0, 3)), 1'($urandom));
      if ($urandom_range(0, 20) == 0) begin
        l_addr = 12'($urandom); r_addr = l_addr;
      end
      if ($urandom_range(0, 40) == 0) master = ~master;
      bin_l = $urandom_range(0, 3) != 0;
      bin_r = $urandom_range(0, 3) != 0;
      if ($urandom_range(0, 500) == 0) rst = 1; else rst = 0;
      step(master ? "R3" : "R8");
    end
    rst = 0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule